// File: doc/BRIEF.md
# Accumulator Register Machine with Direct and Indirect Addressing

This block is a small sequential processor built around a single accumulator. It has a program store, a register file and an accumulator. Each instruction names at most one register. Loads and stores carry a direct/indirect flag. With the flag clear, the operand field is the register address. With the flag set, the operand names a pointer register, and the contents of that register give the address. The effective address is therefore `ind ? [r] : r`.

While `run` is low the machine holds still. The surrounding logic fills the program store and the register file through write ports and inspects them through read ports. When `run` is high the machine executes one step per clock. It stops when it meets a halt instruction or an effective address beyond the register file. An indirect access spends one extra cycle fetching the pointer.

Top module: `acc_machine`

## Requirements
- R1: Reset clears the accumulator, the program counter, every register, every program word, `halted` and `rangeErr`.
- R2: An instruction word is `{op[2:0], ind, opd[DATA_W-1:0], tgt[PC_W-1:0]}`, most significant first. Opcode 0 (load constant) copies `opd` into the accumulator and advances the program counter by one, in one cycle.
- R3: With `ind`=0, opcode 1 (load) copies register `opd` into the accumulator and opcode 2 (store) writes the accumulator into register `opd`. Each takes one cycle and advances the program counter by one.
- R4: With `ind`=1, a load or store first spends one cycle reading register `opd` as a pointer, during which the program counter does not move. In the following cycle it reads or writes the register addressed by the pointer and advances the program counter.
- R5: A register that holds its own address may serve as its own pointer, for both loads and stores.
- R6: Opcode 3 (jump on equal) compares the accumulator with register `opd`, addressed directly. When they are equal the program counter loads `tgt`; otherwise it advances by one.
- R7: Opcode 4 increments the accumulator modulo 2^DATA_W and advances the program counter.
- R8: If an operand, or a pointer's contents, is at or above REG_DEPTH for a load, store or jump, the machine raises `halted` and `rangeErr`. No register is written, the accumulator is unchanged, and the program counter stays on the faulting instruction.
- R9: Opcode 5 raises `halted`. After that, the program counter, the accumulator and the registers stay frozen until reset.
- R10: While `run` is low the machine state does not change, and the write ports update the program store and the register file. While `run` is high, external writes are ignored. The read ports return the program word at `progAddr` and the register at `regRdAddr` at all times.
- R11: Opcodes 6 and 7 do nothing except advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute when high; load/hold when low |
| progWe | input | 1 | Program store write enable |
| progAddr | input | PC_W | Program store write and read address |
| progWrData | input | INSTR_W | Program word to write |
| progRdData | output | INSTR_W | Program word at progAddr |
| regWe | input | 1 | Register file write enable |
| regAddr | input | REG_AW | Register write address |
| regWrData | input | DATA_W | Register write value |
| regRdAddr | input | REG_AW | Register read-back address |
| regRdData | output | DATA_W | Register contents at regRdAddr (zero beyond depth) |
| accOut | output | DATA_W | Accumulator |
| pcOut | output | PC_W | Program counter |
| halted | output | 1 | Machine stopped |
| rangeErr | output | 1 | Stopped on an out-of-range address |

## Verification
The bench builds the block with DATA_W=8, PROG_DEPTH=16 and REG_DEPTH=12. With a register file that is not a power of two deep, operands and pointer values from 12 to 255 are legal encodings that lie outside the file. This exercises the range fault for direct operands, for pointer contents and for the jump operand. The 8-bit width lets the accumulator wrap from 255 to 0 within a two-instruction program. Sixteen program words are enough for a read-modify-write through a pointer, a jump both taken and not taken, and halt freezing, each in a separate run after a reset.

// File: rtl/acc_machine_pkg.sv
package acc_machine_pkg;

  typedef enum logic [2:0] {
    OP_LDK  = 3'd0,
    OP_LDA  = 3'd1,
    OP_STA  = 3'd2,
    OP_JEA  = 3'd3,
    OP_INCA = 3'd4,
    OP_HALT = 3'd5,
    OP_NOP6 = 3'd6,
    OP_NOP7 = 3'd7
  } opcode_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accLoadK;
    logic accLoadReg;
    logic accInc;
    logic regWr;
    logic ptrLoad;
    logic useInd;
    logic pcInc;
    logic pcJump;
    logic setHalt;
    logic setErr;
  } strobe_t;

endpackage

// File: rtl/acc_machine_dp.sv
module acc_machine_dp
  import acc_machine_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int REG_DEPTH  = 16,
  parameter int PROG_DEPTH = 32,
  localparam int PC_W      = $clog2(PROG_DEPTH),
  localparam int REG_AW    = $clog2(REG_DEPTH),
  localparam int INSTR_W   = 4 + DATA_W + PC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  strobe_t            stb,
  input  logic               progWe,
  input  logic [PC_W-1:0]    progAddr,
  input  logic [INSTR_W-1:0] progWrData,
  output logic [INSTR_W-1:0] progRdData,
  input  logic               regWe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [REG_AW-1:0]  regRdAddr,
  output logic [DATA_W-1:0]  regRdData,
  output logic [DATA_W-1:0]  accOut,
  output logic [PC_W-1:0]    pcOut,
  output opcode_t            op,
  output logic               ind,
  output logic               opdOk,
  output logic               ptrOk,
  output logic               accEq
);

  localparam logic [DATA_W:0] DATA_LIM = (DATA_W+1)'(REG_DEPTH);
  localparam logic [REG_AW:0] PORT_LIM = (REG_AW+1)'(REG_DEPTH);

  logic [DATA_W-1:0]  regFile [REG_DEPTH];
  logic [INSTR_W-1:0] progMem [PROG_DEPTH];
  logic [DATA_W-1:0]  accQ;
  logic [DATA_W-1:0]  ptrQ;
  logic [PC_W-1:0]    pcQ;

  logic [INSTR_W-1:0] instr;
  logic [DATA_W-1:0]  opd;
  logic [PC_W-1:0]    tgt;
  logic [DATA_W-1:0]  effSel;
  logic [REG_AW-1:0]  effIdx;
  logic               effOk;
  logic [DATA_W-1:0]  rdVal;
  logic               extRegOk;
  logic               rdPortOk;

  // instruction fields
  assign instr = progMem[pcQ];
  assign op    = opcode_t'(instr[INSTR_W-1 -: 3]);
  assign ind   = instr[INSTR_W-4];
  assign opd   = instr[PC_W +: DATA_W];
  assign tgt   = instr[PC_W-1:0];

  // effective address: operand field or latched pointer
  assign effSel = stb.useInd ? ptrQ : opd;
  assign effOk  = {1'b0, effSel} < DATA_LIM;
  assign effIdx = effSel[REG_AW-1:0];
  assign rdVal  = effOk ? regFile[effIdx] : '0;

  assign opdOk  = {1'b0, opd}  < DATA_LIM;
  assign ptrOk  = {1'b0, ptrQ} < DATA_LIM;
  assign accEq  = (accQ == rdVal);

  // external access
  assign extRegOk   = {1'b0, regAddr}   < PORT_LIM;
  assign rdPortOk   = {1'b0, regRdAddr} < PORT_LIM;
  assign regRdData  = rdPortOk ? regFile[regRdAddr] : '0;
  assign progRdData = progMem[progAddr];
  assign accOut     = accQ;
  assign pcOut      = pcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_DEPTH; i++) regFile[i] <= '0;
    end else begin
      if (!run && regWe && extRegOk) regFile[regAddr] <= regWrData;
      if (stb.regWr && effOk)        regFile[effIdx]  <= accQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PROG_DEPTH; i++) progMem[i] <= '0;
    end else if (!run && progWe) begin
      progMem[progAddr] <= progWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      ptrQ <= '0;
      pcQ  <= '0;
    end else begin
      if (stb.accLoadK)        accQ <= opd;
      else if (stb.accLoadReg) accQ <= rdVal;
      else if (stb.accInc)     accQ <= accQ + 1'b1;
      if (stb.ptrLoad) ptrQ <= rdVal;
      if (stb.pcJump)     pcQ <= tgt;
      else if (stb.pcInc) pcQ <= pcQ + 1'b1;
    end
  end

endmodule

// File: rtl/acc_machine_ctrl.sv
module acc_machine_ctrl
  import acc_machine_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    run,
  input  opcode_t op,
  input  logic    ind,
  input  logic    opdOk,
  input  logic    ptrOk,
  input  logic    accEq,
  output strobe_t stb,
  output logic    halted,
  output logic    rangeErr
);

  typedef enum logic {S_EXEC, S_PTR} phase_t;

  phase_t phaseQ, phaseD;
  logic   haltQ, errQ;

  always_comb begin
    stb    = '0;
    phaseD = phaseQ;
    if (run && !haltQ) begin
      unique case (phaseQ)
        S_EXEC: begin
          unique case (op)
            OP_LDK:  begin stb.accLoadK = 1'b1; stb.pcInc = 1'b1; end
            OP_INCA: begin stb.accInc   = 1'b1; stb.pcInc = 1'b1; end
            OP_HALT: stb.setHalt = 1'b1;
            OP_LDA, OP_STA: begin
              if (!opdOk) begin
                stb.setErr  = 1'b1;
                stb.setHalt = 1'b1;
              end else if (ind) begin
                stb.ptrLoad = 1'b1;
                phaseD      = S_PTR;
              end else begin
                stb.accLoadReg = (op == OP_LDA);
                stb.regWr      = (op == OP_STA);
                stb.pcInc      = 1'b1;
              end
            end
            OP_JEA: begin
              if (!opdOk) begin
                stb.setErr  = 1'b1;
                stb.setHalt = 1'b1;
              end else if (accEq) begin
                stb.pcJump = 1'b1;
              end else begin
                stb.pcInc = 1'b1;
              end
            end
            default: stb.pcInc = 1'b1;
          endcase
        end
        S_PTR: begin
          stb.useInd = 1'b1;
          phaseD     = S_EXEC;
          if (!ptrOk) begin
            stb.setErr  = 1'b1;
            stb.setHalt = 1'b1;
          end else begin
            stb.accLoadReg = (op == OP_LDA);
            stb.regWr      = (op == OP_STA);
            stb.pcInc      = 1'b1;
          end
        end
        default: phaseD = S_EXEC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= S_EXEC;
      haltQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      if (stb.setHalt) haltQ <= 1'b1;
      if (stb.setErr)  errQ  <= 1'b1;
    end
  end

  assign halted   = haltQ;
  assign rangeErr = errQ;

endmodule

// File: rtl/acc_machine.sv
module acc_machine
  import acc_machine_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int REG_DEPTH  = 16,
  parameter int PROG_DEPTH = 32,
  localparam int PC_W      = $clog2(PROG_DEPTH),
  localparam int REG_AW    = $clog2(REG_DEPTH),
  localparam int INSTR_W   = 4 + DATA_W + PC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic               progWe,
  input  logic [PC_W-1:0]    progAddr,
  input  logic [INSTR_W-1:0] progWrData,
  output logic [INSTR_W-1:0] progRdData,
  input  logic               regWe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [REG_AW-1:0]  regRdAddr,
  output logic [DATA_W-1:0]  regRdData,
  output logic [DATA_W-1:0]  accOut,
  output logic [PC_W-1:0]    pcOut,
  output logic               halted,
  output logic               rangeErr
);

  strobe_t stb;
  opcode_t op;
  logic    ind, opdOk, ptrOk, accEq;

  acc_machine_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .run(run),
    .op(op), .ind(ind), .opdOk(opdOk), .ptrOk(ptrOk), .accEq(accEq),
    .stb(stb), .halted(halted), .rangeErr(rangeErr)
  );

  acc_machine_dp #(
    .DATA_W(DATA_W), .REG_DEPTH(REG_DEPTH), .PROG_DEPTH(PROG_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .run(run), .stb(stb),
    .progWe(progWe), .progAddr(progAddr), .progWrData(progWrData),
    .progRdData(progRdData),
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .accOut(accOut), .pcOut(pcOut),
    .op(op), .ind(ind), .opdOk(opdOk), .ptrOk(ptrOk), .accEq(accEq)
  );

endmodule

// File: rtl/acc_machine_chk.sv
module acc_machine_chk
  import acc_machine_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int PC_W  = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             halted,
  input logic             rangeErr,
  input logic [ACC_W-1:0] accOut,
  input logic [PC_W-1:0]  pcOut,
  input strobe_t          stb
);

  // R8: a range fault always stops the machine
  p_err_halts_r8: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> halted);

  // R9: once stopped, pc, accumulator and halted stay put
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pcOut) && $stable(accOut)));

  // R10: with run low, nothing in the machine moves
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> ($stable(pcOut) && $stable(accOut)));

  // R4: the pointer-fetch cycle leaves the program counter unchanged
  p_ptr_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrLoad |=> $stable(pcOut));

  // R2: at most one accumulator source per cycle
  p_acc_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.accLoadK, stb.accLoadReg, stb.accInc}));

endmodule

bind acc_machine acc_machine_chk #(.ACC_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .run(run), .halted(halted), .rangeErr(rangeErr),
  .accOut(accOut), .pcOut(pcOut), .stb(stb)
);

// File: tb/sim_acc_machine.sv
`timescale 1ns/1ps
module sim_acc_machine;

  localparam int DW = 8;
  localparam int RD = 12;
  localparam int PD = 16;
  localparam int PW = 4;
  localparam int AW = 4;
  localparam int IW = 4 + DW + PW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic progWe = 1'b0;
  logic [PW-1:0] progAddr = '0;
  logic [IW-1:0] progWrData = '0;
  logic [IW-1:0] progRdData;
  logic regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [AW-1:0] regRdAddr = '0;
  logic [DW-1:0] regRdData;
  logic [DW-1:0] accOut;
  logic [PW-1:0] pcOut;
  logic halted, rangeErr;

  always #2.5 clk = ~clk;

  acc_machine #(.DATA_W(DW), .REG_DEPTH(RD), .PROG_DEPTH(PD)) u0 (
    .clk(clk), .rstN(rstN), .run(run),
    .progWe(progWe), .progAddr(progAddr), .progWrData(progWrData),
    .progRdData(progRdData),
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .accOut(accOut), .pcOut(pcOut), .halted(halted), .rangeErr(rangeErr)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mAcc, mPc, mPtr, mPhase;
  bit mHalt, mErr;
  int mRegs [RD];
  logic [IW-1:0] mProg [PD];

  function automatic logic [IW-1:0] mk(logic [2:0] op, logic ind, logic [7:0] opd, logic [3:0] tgt);
    return {op, ind, opd, tgt};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelStep();
    if (!rstN) begin
      mAcc = 0; mPc = 0; mPtr = 0; mPhase = 0; mHalt = 0; mErr = 0;
      for (int i = 0; i < RD; i++) mRegs[i] = 0;
      for (int i = 0; i < PD; i++) mProg[i] = '0;
    end else if (!run) begin
      if (progWe) mProg[progAddr] = progWrData;
      if (regWe && int'(regAddr) < RD) mRegs[regAddr] = int'(regWrData);
    end else if (!mHalt) begin
      int op, ind, opd, tgt;
      op  = int'(mProg[mPc][15:13]);
      ind = int'(mProg[mPc][12]);
      opd = int'(mProg[mPc][11:4]);
      tgt = int'(mProg[mPc][3:0]);
      if (mPhase == 1) begin
        mPhase = 0;
        if (mPtr >= RD) begin mHalt = 1; mErr = 1; end
        else begin
          if (op == 1) mAcc = mRegs[mPtr]; else mRegs[mPtr] = mAcc;
          mPc = (mPc + 1) % PD;
        end
      end else begin
        case (op)
          0: begin mAcc = opd; mPc = (mPc + 1) % PD; end
          4: begin mAcc = (mAcc + 1) % 256; mPc = (mPc + 1) % PD; end
          5: mHalt = 1;
          1, 2: begin
            if (opd >= RD) begin mHalt = 1; mErr = 1; end
            else if (ind == 1) begin mPtr = mRegs[opd]; mPhase = 1; end
            else begin
              if (op == 1) mAcc = mRegs[opd]; else mRegs[opd] = mAcc;
              mPc = (mPc + 1) % PD;
            end
          end
          3: begin
            if (opd >= RD) begin mHalt = 1; mErr = 1; end
            else if (mAcc == mRegs[opd]) mPc = tgt;
            else mPc = (mPc + 1) % PD;
          end
          default: mPc = (mPc + 1) % PD;
        endcase
      end
    end
  endtask

  // one clock: advance the model, let the edge pass, compare away from it
  task automatic tick();
    int expRd;
    modelStep();
    @(posedge clk);
    #2;
    expRd = (int'(regRdAddr) < RD) ? mRegs[regRdAddr] : 0;
    checks++;
    if (int'(accOut) != mAcc || int'(pcOut) != mPc || halted != mHalt ||
        rangeErr != mErr || int'(regRdData) != expRd ||
        progRdData != mProg[progAddr]) begin
      errors++;
      $display("FAIL lockstep actual acc=%0d pc=%0d h=%0d e=%0d rd=%0d prog=%h expected acc=%0d pc=%0d h=%0d e=%0d rd=%0d prog=%h",
               accOut, pcOut, halted, rangeErr, regRdData, progRdData,
               mAcc, mPc, mHalt, mErr, expRd, mProg[progAddr]);
    end
  endtask

  task automatic doReset();
    run = 1'b0; rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic putProg(int a, logic [IW-1:0] w);
    progWe = 1'b1; progAddr = PW'(a); progWrData = w;
    tick();
    progWe = 1'b0;
  endtask

  task automatic putReg(int a, int v);
    regWe = 1'b1; regAddr = AW'(a); regWrData = DW'(v);
    tick();
    regWe = 1'b0;
  endtask

  function automatic int peek(int a);
    return 0;
  endfunction

  task automatic readReg(int a, output int v);
    regRdAddr = AW'(a);
    #1;
    v = int'(regRdData);
  endtask

  task automatic runToHalt(int limit);
    run = 1'b1;
    for (int i = 0; i < limit && !mHalt; i++) tick();
    run = 1'b0;
    tick();
  endtask

  initial begin
    int v;
    doReset();
    // R1: reset state
    chk("R1 acc", int'(accOut), 0);
    chk("R1 pc", int'(pcOut), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 rangeErr", int'(rangeErr), 0);
    readReg(3, v); chk("R1 register", v, 0);

    // ---- program A: constant, direct/indirect, read-modify-write, jumps
    putReg(3, 5); putReg(4, 2); putReg(5, 33);
    putProg(0,  mk(3'd0, 1'b0, 8'd9, 4'd0));   // LDK 9
    putProg(1,  mk(3'd2, 1'b0, 8'd1, 4'd0));   // STA r1
    putProg(2,  mk(3'd1, 1'b1, 8'd3, 4'd0));   // LDA [r3]
    putProg(3,  mk(3'd4, 1'b0, 8'd0, 4'd0));   // INCA
    putProg(4,  mk(3'd2, 1'b1, 8'd3, 4'd0));   // STA [r3]
    putProg(5,  mk(3'd1, 1'b0, 8'd4, 4'd0));   // LDA r4
    putProg(6,  mk(3'd3, 1'b0, 8'd5, 4'd10));  // JEA r5,10 (not taken)
    putProg(7,  mk(3'd1, 1'b0, 8'd5, 4'd0));   // LDA r5
    putProg(8,  mk(3'd3, 1'b0, 8'd5, 4'd10));  // JEA r5,10 (taken)
    putProg(9,  mk(3'd0, 1'b0, 8'd99, 4'd0));  // skipped
    putProg(10, mk(3'd5, 1'b0, 8'd0, 4'd0));   // HALT
    progAddr = 4'd2;
    #1 chk("R10 program read-back", int'(progRdData), int'(mk(3'd1, 1'b1, 8'd3, 4'd0)));
    readReg(5, v); chk("R10 register load", v, 33);

    run = 1'b1;
    regWe = 1'b1; regAddr = 4'd1; regWrData = 8'd77;  // must be ignored (R10)
    tick(); chk("R2 constant load", int'(accOut), 9);
    chk("R2 pc step", int'(pcOut), 1);
    tick(); readReg(1, v); chk("R3 direct store", v, 9);
    tick(); chk("R4 pointer cycle holds pc", int'(pcOut), 2);
    tick(); chk("R4 indirect load", int'(accOut), 33);
    chk("R4 pc after access", int'(pcOut), 3);
    for (int i = 0; i < 30 && !mHalt; i++) tick();
    regWe = 1'b0;
    chk("R6 taken jump reaches halt", int'(pcOut), 10);
    chk("R6 skipped word not run", int'(accOut), 34);
    readReg(5, v); chk("R4 read-modify-write result", v, 34);
    readReg(1, v); chk("R10 write ignored while running", v, 9);
    readReg(4, v); chk("R3 direct load source intact", v, 2);
    tick(); tick(); tick();
    chk("R9 pc frozen", int'(pcOut), 10);
    chk("R9 halted", int'(halted), 1);
    chk("R9 no range error", int'(rangeErr), 0);
    run = 1'b0; tick();

    // ---- program B: self pointer, wrap, no-op
    doReset();
    putReg(6, 6);
    putProg(0, mk(3'd1, 1'b1, 8'd6, 4'd0));    // LDA [r6] -> 6
    putProg(1, mk(3'd2, 1'b0, 8'd0, 4'd0));    // STA r0
    putProg(2, mk(3'd0, 1'b0, 8'd255, 4'd0));  // LDK 255
    putProg(3, mk(3'd4, 1'b0, 8'd0, 4'd0));    // INCA -> 0
    putProg(4, mk(3'd6, 1'b1, 8'd3, 4'd9));    // no-op
    putProg(5, mk(3'd7, 1'b0, 8'd1, 4'd2));    // no-op
    putProg(6, mk(3'd2, 1'b1, 8'd6, 4'd0));    // STA [r6]
    putProg(7, mk(3'd5, 1'b0, 8'd0, 4'd0));    // HALT
    runToHalt(40);
    readReg(0, v); chk("R5 self-pointer load", v, 6);
    readReg(6, v); chk("R5 self-pointer store", v, 0);
    chk("R7 increment wraps", int'(accOut), 0);
    chk("R11 no-ops advance to halt", int'(pcOut), 7);
    chk("R11 no-op leaves registers", int'(rangeErr), 0);

    // ---- program C: pointer contents out of range
    doReset();
    putReg(7, 200);
    putProg(0, mk(3'd0, 1'b0, 8'd42, 4'd0));   // LDK 42
    putProg(1, mk(3'd2, 1'b1, 8'd7, 4'd0));    // STA [r7], r7=200
    putProg(2, mk(3'd0, 1'b0, 8'd1, 4'd0));
    runToHalt(20);
    chk("R8 pointer fault flag", int'(rangeErr), 1);
    chk("R8 pointer fault halts", int'(halted), 1);
    chk("R8 pc on faulting word", int'(pcOut), 1);
    chk("R8 acc unchanged", int'(accOut), 42);
    readReg(7, v); chk("R8 pointer register intact", v, 200);
    for (int i = 0; i < RD; i++) begin
      if (i != 7) begin readReg(i, v); chk("R8 no write", v, 0); end
    end

    // ---- program D: direct operand out of range, jump operand out of range
    doReset();
    putProg(0, mk(3'd1, 1'b0, 8'd12, 4'd0));
    runToHalt(10);
    chk("R8 direct operand fault", int'(rangeErr), 1);
    chk("R8 direct fault pc", int'(pcOut), 0);
    doReset();
    putProg(0, mk(3'd0, 1'b0, 8'd0, 4'd0));
    putProg(1, mk(3'd3, 1'b0, 8'd255, 4'd0));
    runToHalt(10);
    chk("R8 jump operand fault", int'(rangeErr), 1);
    chk("R8 jump fault pc", int'(pcOut), 1);

    // R10: idle machine holds while run low
    doReset();
    putProg(0, mk(3'd0, 1'b0, 8'd5, 4'd0));
    tick(); tick();
    chk("R10 idle pc", int'(pcOut), 0);
    chk("R10 idle acc", int'(accOut), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule